// File: doc/BRIEF.md
# Serial Converter Host Master

This block is the host side of a three-wire link to an 8-bit successive-approximation converter. A user request gives the input configuration (a mode bit for single-ended or differential, and an odd/sign bit that picks the channel or the polarity) and a divider value. The master then runs one full conversion. It lowers chip select and toggles the serial clock. It sends a start bit and the two address bits. It releases the data line for the settling slot and then collects the result twice: most significant bit first, and then as an echo with the least significant bit first.

The two copies of the result are compared. The 8-bit sample is returned with a one-cycle valid strobe, and an error flag is set whenever any echoed bit disagrees with the bit of the same weight in the first copy. With the default parameter, the master's data driver carries an output enable. This allows the converter's input and output to share one bidirectional wire: the master lets go of the wire as soon as the address has been sent.

Top module: `sadc_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, req_ready is 1, rsp_valid is 0 and di_oe is 0 (shared-pin build).
- R2: Every sclk high phase and every sclk low phase between two high phases lasts req_div+1 system clocks, so the duty cycle is 50 percent for any divider.
- R3: At the 1st, 2nd and 3rd sclk rising edges, di_out holds 1 (the start bit), then req_mode_se, then req_odd_sign. di_out changes only while sclk is low.
- R4: In the shared-pin build, di_oe is 1 at rising edges 1 to 3 and falls together with the 3rd falling edge. It stays 0 until cs_n returns high, so it never overlaps with the converter driving the line.
- R5: The bit on do_in at the 4th rising edge (the settling slot) is discarded and has no effect on rsp_data or rsp_err.
- R6: rsp_data is the value formed by the do_in bits at rising edges 5 to 12, the first of them being bit 7.
- R7: The do_in bits at rising edges 13 to 19 are the echo of result bits 1 to 7, in that order (bit 0 is not repeated). rsp_err is 1 exactly when at least one of them differs from the matching bit of rsp_data.
- R8: cs_n stays low from the cycle after acceptance until the end of the transfer. The transfer has exactly 19 sclk rising edges, and cs_n rises 2*(req_div+1) clocks after the last falling edge, with sclk held low.
- R9: rsp_valid is a single-cycle pulse in the first cycle with cs_n high again. req_ready is 0 for the whole transfer, so a request held high during a transfer starts nothing until the pulse has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Master idle and able to take a request |
| req_mode_se | input | 1 | Mode bit sent after the start bit |
| req_odd_sign | input | 1 | Channel or polarity bit sent last |
| req_div | input | DIV_W | Half-period of sclk minus one, in system clocks |
| rsp_valid | output | 1 | One-cycle strobe marking a finished conversion |
| rsp_data | output | RES_W | Converted sample |
| rsp_err | output | 1 | Echo mismatch flag, valid with rsp_valid |
| cs_n | output | 1 | Converter select, active low |
| sclk | output | 1 | Serial clock, idle low |
| di_out | output | 1 | Serial data to the converter |
| di_oe | output | 1 | Drive enable for di_out on a shared wire |
| do_in | input | 1 | Serial data from the converter (the shared wire in single-pin use) |

## Verification
Every 8-bit result value is run through a converter model with the slow divider at its minimum. The low address bits of each value walk through all four mode and sign combinations, so each bit position of the data path is seen both set and cleared, with both neighbours. The value placed in the settling slot alternates between 0 and 1, which separates a correct discard from an off-by-one capture. Dividers from 1 to 6 check the phase widths and the chip-select tail. A corrupted echo bit is injected at each position 1 to 7 to show that the comparison covers every weight, and a request held high through a transfer shows that nothing is accepted while busy.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // Transfer framing counted in serial clock rising edges.
  localparam int ADDR_LEN   = 3;  // start bit plus two address bits
  localparam int SETTLE_LEN = 1;  // discarded settling slot
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sadc_state_e;
endpackage

// File: rtl/sadc_halfgen.sv
// Divides the system clock into serial-clock half periods and counts them.
module sadc_halfgen #(
  parameter int DIV_W  = 8,
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  output logic              tick,
  output logic [HALF_W-1:0] half
);
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [HALF_W-1:0] half_q, half_d;

  assign tick = run && (cnt_q == div);
  assign half = half_q;

  always_comb begin
    cnt_d  = cnt_q;
    half_d = half_q;
    if (!run) begin
      cnt_d  = '0;
      half_d = '0;
    end else if (tick) begin
      cnt_d  = '0;
      half_d = half_q + 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
    end
  end
endmodule

// File: rtl/sadc_capture.sv
// Samples the converter output at rising edges; builds the result and
// compares the echoed copy bit by bit.
module sadc_capture #(
  parameter int RES_W     = 8,
  parameter int HALF_W    = 6,
  parameter int RISE_MSB0 = 5,
  parameter int RISE_ECHO = 13,
  parameter int RISE_LAST = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic [HALF_W-1:0] half,
  input  logic              sdi,
  output logic [RES_W-1:0]  res,
  output logic              err
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [HALF_W-1:0] K_MSB0 = HALF_W'(RISE_MSB0);
  localparam logic [HALF_W-1:0] K_ECHO = HALF_W'(RISE_ECHO);
  localparam logic [HALF_W-1:0] K_LAST = HALF_W'(RISE_LAST);
  localparam logic [HALF_W-1:0] K_EOFS = HALF_W'(RISE_ECHO - 1);

  logic [RES_W-1:0]  res_q, res_d;
  logic              err_q, err_d;
  logic [HALF_W-1:0] rise_k;
  logic [IDX_W-1:0]  eidx;

  // A tick during an even half period ends a low phase: rising edge rise_k.
  assign rise_k = HALF_W'((half >> 1) + 1'b1);
  assign eidx   = IDX_W'(rise_k - K_EOFS);
  assign res    = res_q;
  assign err    = err_q;

  always_comb begin
    res_d = res_q;
    err_d = err_q;
    if (clr) begin
      res_d = '0;
      err_d = 1'b0;
    end else if (tick && !half[0]) begin
      if (rise_k >= K_MSB0 && rise_k < K_ECHO)
        res_d = {res_q[RES_W-2:0], sdi};
      else if (rise_k >= K_ECHO && rise_k <= K_LAST)
        err_d = err_q | (sdi != res_q[eidx]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      res_q <= res_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/sadc_master.sv
module sadc_master
  import sadc_pkg::*;
#(
  parameter int RES_W      = 8,
  parameter int DIV_W      = 8,
  parameter bit SHARED_PIN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_mode_se,
  input  logic             req_odd_sign,
  input  logic [DIV_W-1:0] req_div,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_data,
  output logic             rsp_err,
  output logic             cs_n,
  output logic             sclk,
  output logic             di_out,
  output logic             di_oe,
  input  logic             do_in
);
  localparam int RISE_MSB0 = ADDR_LEN + SETTLE_LEN + 1;
  localparam int RISE_ECHO = RISE_MSB0 + RES_W;
  localparam int RISE_LAST = RISE_ECHO + RES_W - 2;
  localparam int HALF_LAST = 2 * RISE_LAST + 1;
  localparam int HALF_W    = $clog2(HALF_LAST + 1);
  localparam logic [HALF_W-1:0] H_LAST  = HALF_W'(HALF_LAST);
  localparam logic [HALF_W-1:0] H_HIEND = HALF_W'(2 * RISE_LAST - 1);
  localparam logic [HALF_W-1:0] H_MODE  = HALF_W'(2);
  localparam logic [HALF_W-1:0] H_ODD   = HALF_W'(4);
  localparam logic [HALF_W-1:0] H_REL   = HALF_W'(2 * ADDR_LEN);

  sadc_state_e      state_q, state_d;
  logic [DIV_W-1:0] div_q;
  logic             mode_q, odd_q, vld_q;
  logic             accept, run, tick, finish;
  logic [HALF_W-1:0] half;

  assign run    = (state_q == ST_RUN);
  assign accept = req_valid && !run;
  assign finish = tick && (half == H_LAST);

  sadc_halfgen #(.DIV_W(DIV_W), .HALF_W(HALF_W)) u_halfgen (
    .clk (clk), .rst_n (rst_n), .run (run), .div (div_q),
    .tick (tick), .half (half)
  );

  sadc_capture #(
    .RES_W (RES_W), .HALF_W (HALF_W), .RISE_MSB0 (RISE_MSB0),
    .RISE_ECHO (RISE_ECHO), .RISE_LAST (RISE_LAST)
  ) u_capture (
    .clk (clk), .rst_n (rst_n), .clr (accept), .tick (tick),
    .half (half), .sdi (do_in), .res (rsp_data), .err (rsp_err)
  );

  always_comb begin
    state_d = state_q;
    if (accept)      state_d = ST_RUN;
    else if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= finish;
    end
  end

  // Request fields: clock enable on acceptance only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      mode_q <= 1'b0;
      odd_q  <= 1'b0;
    end else if (accept) begin
      div_q  <= req_div;
      mode_q <= req_mode_se;
      odd_q  <= req_odd_sign;
    end
  end

  assign req_ready = !run;
  assign rsp_valid = vld_q;
  assign cs_n      = !run;
  assign sclk      = run && half[0] && (half <= H_HIEND);

  always_comb begin
    di_out = 1'b0;
    if (run) begin
      if (half < H_MODE)     di_out = 1'b1;
      else if (half < H_ODD) di_out = mode_q;
      else if (half < H_REL) di_out = odd_q;
    end
  end

  generate
    if (SHARED_PIN) begin : g_shared
      assign di_oe = run && (half < H_REL);
    end else begin : g_split
      assign di_oe = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/sadc_master_chk.sv
module sadc_master_chk #(
  parameter bit SHARED_PIN = 1'b1
) (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_valid,
  input logic cs_n,
  input logic sclk,
  input logic di_out,
  input logic di_oe
);
  a_r8_sclk_low_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  a_r3_di_moves_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(di_out) |-> !sclk);

  a_r9_valid_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_valid_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (cs_n && !$past(cs_n)));

  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  generate
    if (SHARED_PIN) begin : g_oe
      a_r4_release_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !di_oe) |=> (cs_n || !di_oe));
    end
  endgenerate
endmodule

bind sadc_master sadc_master_chk #(.SHARED_PIN(SHARED_PIN)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_ready (req_ready), .rsp_valid (rsp_valid),
  .cs_n (cs_n), .sclk (sclk), .di_out (di_out), .di_oe (di_oe)
);

// File: tb/sadc_master_tb.sv
module sadc_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_mode_se = 1'b0;
  logic       req_odd_sign = 1'b0;
  logic [7:0] req_div = '0;
  logic       req_ready, rsp_valid, rsp_err, cs_n, sclk, di_out, di_oe, do_in;
  logic [7:0] rsp_data;

  // Converter model state
  int   cur_val = 0;
  logic lead_bit = 1'b0;
  int   inj_pos = 0;
  logic slave_en = 1'b0;
  logic slave_do = 1'b0;
  int   rcnt = 0;

  // Monitor state
  int   cur_div = 0;
  int   rises = 0, run_len = 0, width_bad = 0, oe_bad = 0, clash = 0, tail_len = 0;
  logic [2:0] addr_rx = '0;
  logic prev_cs = 1'b1, prev_s = 1'b0;

  int   n_chk = 0, n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  assign do_in = di_oe ? di_out : slave_do;

  sadc_master u_dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_mode_se (req_mode_se), .req_odd_sign (req_odd_sign), .req_div (req_div),
    .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_err (rsp_err),
    .cs_n (cs_n), .sclk (sclk), .di_out (di_out), .di_oe (di_oe), .do_in (do_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Converter model: output changes on falling edges of sclk.
  initial begin
    forever begin
      @(sclk or cs_n);
      if (cs_n) begin
        rcnt = 0; slave_en = 1'b0; slave_do = 1'b0;
      end else if (sclk) begin
        rcnt++;
      end else begin
        if (rcnt == 3) begin
          slave_en = 1'b1; slave_do = lead_bit;
        end else if (rcnt >= 4 && rcnt <= 11) begin
          slave_do = cur_val[11 - rcnt];
        end else if (rcnt >= 12 && rcnt <= 18) begin
          slave_do = cur_val[rcnt - 11] ^ (inj_pos == rcnt - 11);
        end
      end
    end
  end

  // Pin monitor, sampled away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (!cs_n) begin
        if (prev_cs) begin
          rises = 0; run_len = 0; width_bad = 0; oe_bad = 0; clash = 0; addr_rx = '0; prev_s = 1'b0;
        end
        if (sclk != prev_s) begin
          if (prev_s) begin
            if (run_len != cur_div + 1) width_bad++;
          end else if (rises > 0 && run_len != cur_div + 1) width_bad++;
          if (sclk) begin
            rises++;
            if (rises <= 3) addr_rx[rises-1] = di_out;
            if (di_oe != (rises <= 3)) oe_bad++;
          end
          run_len = 1;
        end else begin
          run_len++;
        end
        if (di_oe && slave_en) clash++;
      end else if (!prev_cs) begin
        tail_len = run_len;
      end
      prev_cs = cs_n;
      prev_s  = sclk;
    end
  end

  task automatic run_tx(input int val, input int dv, input bit mode, input bit odd,
                        input bit lead, input int inj, input bit hold);
    int busy_bad;
    busy_bad = 0;
    cur_val = val; lead_bit = lead; inj_pos = inj; cur_div = dv;
    @(negedge clk);
    req_valid = 1'b1; req_div = 8'(dv); req_mode_se = mode; req_odd_sign = odd;
    @(negedge clk);
    if (!hold) req_valid = 1'b0;
    while (!rsp_valid) begin
      if (req_ready) busy_bad++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(rsp_data == 8'(val), "R6 data", int'(rsp_data), val);
    chk(rsp_err == (inj != 0), "R7 echo error", int'(rsp_err), int'(inj != 0));
    chk(cs_n == 1'b1, "R9 valid with cs high", int'(cs_n), 1);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R9 valid pulse width", int'(rsp_valid), 0);
    chk(addr_rx == {odd, mode, 1'b1}, "R3 address bits", int'(addr_rx), int'({odd, mode, 1'b1}));
    chk(width_bad == 0, "R2 phase width", width_bad, 0);
    chk(oe_bad == 0 && clash == 0, "R4 drive enable", oe_bad + clash, 0);
    chk(rises == 19, "R8 rising edges", rises, 19);
    chk(tail_len == 2 * (dv + 1), "R8 deselect tail", tail_len, 2 * (dv + 1));
    if (hold) begin
      chk(busy_bad == 0, "R9 ready low while busy", busy_bad, 0);
      repeat (3) begin
        @(negedge clk);
        chk(cs_n == 1'b1, "R9 no start from held request", int'(cs_n), 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    chk(di_oe == 1'b0, "R1 di_oe", int'(di_oe), 0);

    // Full value sweep; settling slot alternates (R5).
    for (int v = 0; v < 256; v++)
      run_tx(v, 0, v[0], v[1], v[2], 0, 1'b0);
    // Slower dividers (R2, R8).
    for (int d = 1; d <= 6; d++)
      for (int k = 0; k < 4; k++)
        run_tx((d * 37 + k * 91) % 256, d, k[0], k[1], k[0] ^ k[1], 0, 1'b0);
    // Corrupted echo at every position (R7).
    for (int p = 1; p <= 7; p++) begin
      run_tx(8'hA5, 1, 1'b1, 1'b0, 1'b0, p, 1'b0);
      run_tx(8'h3C, 0, 1'b0, 1'b1, 1'b1, p, 1'b0);
    end
    // Clean transfer after errors clears the flag (R7), then held request (R9).
    run_tx(8'hFF, 2, 1'b1, 1'b1, 1'b1, 0, 1'b0);
    run_tx(8'h00, 0, 1'b0, 1'b0, 1'b1, 0, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule